// File: doc/BRIEF.md
# Lockable Write-Protect Setting and Range Checker

This block holds a four-bit protection setting for an addressable storage array. From that setting it works out which upper fraction of the array is closed to writes. It then compares each array write address against that fraction. The serial bus controller around it does three things with the block:

- It forwards register write requests, each carrying its data byte count.
- It asks for register readbacks.
- It presents every array write address for judgement. When the protect flag is high, the controller answers the data byte with NoAck and drops the array update.

The setting has four fields. The enable field is bit 3 and switches protection on. The size field is bits 2:1 and picks the closed region. The lock field is bit 0; once it is set, the setting is frozen until reset. The setting clears to zero at reset, so the array starts fully writable. Register reads need no handshake on the request side. A read request is taken in the cycle it is raised, and its response comes one cycle later as a single-cycle `rd_done` strobe. The block never back-pressures, so the controller must capture the response in the cycle `rd_done` is high.

Top module: `wprot_guard`

## Requirements
- R1: After reset the setting is 00h: `rd_data` reads 00h and `chk_prot` is 0 for every address.
- R2: While setting bit 3 (enable) is 0, `chk_prot` is 0 for every address, whatever bits 2:1 hold.
- R3: While enabled, an address is protected when its two most significant bits are at or above a floor. The floor comes from bits 2:1 (size): size 00 gives floor 11 (top quarter), 01 gives 10 (top half), 10 gives 01 (top three quarters), and 11 gives 00 (whole array).
- R4: A register write with `wr_count` equal to 1 loads `wr_data[3:0]` into the setting, visible from the cycle after `wr_en`. `wr_data[7:4]` have no effect.
- R5: A register write with `wr_count` other than 1 (zero, or more than one byte) leaves the setting unchanged.
- R6: Once setting bit 0 (lock) is 1, no register write changes the setting until reset.
- R7: A read request (`rd_en`) with `wcyc_busy` low gives, in the next cycle, `rd_done`=1, `rd_ok`=1 and `rd_data` = {4'b0000, setting[3:0]}.
- R8: Back-to-back read requests each return the same setting value.
- R9: A read request while `wcyc_busy` is high gives, in the next cycle, `rd_done`=1, `rd_ok`=0 and `rd_data`=00h, so the controller can send a busy NoAck.
- R10: Reads are granted whatever the protection state, including while the whole array is protected and locked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write request, one cycle |
| wr_data | input | 8 | Register write data byte |
| wr_count | input | CNT_W | Data bytes carried by the register write |
| rd_en | input | 1 | Register read request, one cycle |
| wcyc_busy | input | 1 | Internal array write cycle in progress |
| rd_done | output | 1 | Read response strobe |
| rd_ok | output | 1 | Read granted (1) or refused as busy (0) |
| rd_data | output | 8 | Readback byte |
| chk_addr | input | ADDR_W | Array write address to judge |
| chk_prot | output | 1 | Address lies in the protected region |

## Verification
The assertions assume that `rd_en` and `wr_en` are clean single-cycle levels, sampled at rising edges. They also assume that `wcyc_busy` holds steady through the edge where a read request is taken. The bench drives every input on the falling clock edge, so each value is settled well before the rising edge that uses it. Addresses are always within the array's width, and the write byte counts cover zero, one and several bytes.

// File: rtl/wprot_pkg.sv
package wprot_pkg;
  typedef struct packed {
    logic       en;
    logic [1:0] size;
    logic       lock;
  } wp_cfg_t;

  localparam int CFG_W = $bits(wp_cfg_t);

  // lowest top-two-bit value that falls inside the protected region
  function automatic logic [1:0] region_floor(input logic [1:0] size);
    return ~size;
  endfunction
endpackage

// File: rtl/wprot_cfg_reg.sv
module wprot_cfg_reg
  import wprot_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [7:0]       wr_data,
  input  logic [CNT_W-1:0] wr_count,
  output wp_cfg_t          cfg
);
  localparam logic [CNT_W-1:0] ONE_BYTE = CNT_W'(1);

  logic take;
  assign take = wr_en && (wr_count == ONE_BYTE) && !cfg.lock;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg <= '0;
    else if (take) cfg <= wp_cfg_t'(wr_data[CFG_W-1:0]);
  end

  // R6
  lock_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cfg.lock) |-> $stable(cfg));

  // R5
  count_discard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_count != ONE_BYTE) |=> $stable(cfg));
endmodule

// File: rtl/wprot_range.sv
module wprot_range
  import wprot_pkg::*;
#(
  parameter int ADDR_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  wp_cfg_t           cfg,
  input  logic [ADDR_W-1:0] addr,
  output logic              prot
);
  localparam int TOP = ADDR_W - 1;

  logic [1:0] quarter;

  generate
    if (ADDR_W >= 2) begin : g_wide
      assign quarter = addr[TOP -: 2];
    end else begin : g_narrow
      assign quarter = {addr[0], 1'b0};
    end
  endgenerate

  assign prot = cfg.en && (quarter >= region_floor(cfg.size));

  // R2
  off_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg.en |-> !prot);

  // R3
  whole_array_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.en && cfg.size == 2'b11) |-> prot);

  // R3
  top_quarter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.en && quarter == 2'b11) |-> prot);
endmodule

// File: rtl/wprot_readback.sv
module wprot_readback
  import wprot_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rd_en,
  input  logic       busy,
  input  wp_cfg_t    cfg,
  output logic       rd_done,
  output logic       rd_ok,
  output logic [7:0] rd_data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_done <= 1'b0;
      rd_ok   <= 1'b0;
      rd_data <= '0;
    end else begin
      rd_done <= rd_en;
      rd_ok   <= rd_en && !busy;
      rd_data <= (rd_en && !busy) ? {{(8 - CFG_W){1'b0}}, cfg} : 8'h00;
    end
  end

  // R9
  busy_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && busy) |=> (rd_done && !rd_ok && rd_data == 8'h00));

  // R7
  grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !busy) |=> (rd_done && rd_ok && rd_data[7:4] == 4'h0));
endmodule

// File: rtl/wprot_guard.sv
module wprot_guard
  import wprot_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int CNT_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [7:0]        wr_data,
  input  logic [CNT_W-1:0]  wr_count,
  input  logic              rd_en,
  input  logic              wcyc_busy,
  output logic              rd_done,
  output logic              rd_ok,
  output logic [7:0]        rd_data,
  input  logic [ADDR_W-1:0] chk_addr,
  output logic              chk_prot
);
  wp_cfg_t cfg;

  wprot_cfg_reg #(.CNT_W(CNT_W)) cfg_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .wr_count(wr_count), .cfg(cfg)
  );

  wprot_range #(.ADDR_W(ADDR_W)) range_i (
    .clk(clk), .rst_n(rst_n), .cfg(cfg), .addr(chk_addr), .prot(chk_prot)
  );

  wprot_readback read_i (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .busy(wcyc_busy), .cfg(cfg),
    .rd_done(rd_done), .rd_ok(rd_ok), .rd_data(rd_data)
  );

  // R8
  repeat_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rd_ok) && rd_ok && $stable(cfg)) |-> $stable(rd_data));
endmodule

// File: tb/wprot_guard_tb_top.sv
module wprot_guard_tb_top;
  localparam int AW = 14;
  localparam int CW = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [7:0]    wr_data = '0;
  logic [CW-1:0] wr_count = '0;
  logic          rd_en = 1'b0;
  logic          wcyc_busy = 1'b0;
  logic          rd_done, rd_ok, chk_prot;
  logic [7:0]    rd_data;
  logic [AW-1:0] chk_addr = '0;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  wprot_guard #(.ADDR_W(AW), .CNT_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .wr_count(wr_count), .rd_en(rd_en), .wcyc_busy(wcyc_busy),
    .rd_done(rd_done), .rd_ok(rd_ok), .rd_data(rd_data),
    .chk_addr(chk_addr), .chk_prot(chk_prot)
  );

  // {setting[3:0], address, expected protect}
  localparam logic [18:0] VEC [12] = '{
    {4'b0000, 14'h3FFF, 1'b0},
    {4'b0110, 14'h3FFF, 1'b0},
    {4'b1000, 14'h3000, 1'b1},
    {4'b1000, 14'h2FFF, 1'b0},
    {4'b1010, 14'h2000, 1'b1},
    {4'b1010, 14'h1FFF, 1'b0},
    {4'b1100, 14'h1000, 1'b1},
    {4'b1100, 14'h0FFF, 1'b0},
    {4'b1110, 14'h0000, 1'b1},
    {4'b1110, 14'h3FFF, 1'b1},
    {4'b1000, 14'h3FFF, 1'b1},
    {4'b1100, 14'h0000, 1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [7:0] d, input int n);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d; wr_count = CW'(n);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // single read; response sampled on the falling edge after the taking edge
  task automatic reg_read(input logic busy, output logic ok, output logic [7:0] d, output logic dn);
    @(negedge clk);
    rd_en = 1'b1; wcyc_busy = busy;
    @(negedge clk);
    rd_en = 1'b0; wcyc_busy = 1'b0;
    dn = rd_done; ok = rd_ok; d = rd_data;
  endtask

  task automatic probe(input logic [AW-1:0] a, output logic p);
    chk_addr = a;
    #1;
    p = chk_prot;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic ok, dn, p;
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    reg_read(1'b0, ok, d, dn);
    check("R1 reset readback", d, 8'h00);
    probe(14'h3FFF, p);
    check("R1 reset unprotected", p, 1'b0);

    // R2 R3 table walk
    foreach (VEC[i]) begin
      reg_write({4'h0, VEC[i][18:15]}, 1);
      probe(VEC[i][14:1], p);
      check($sformatf("R3 vector %0d", i), p, VEC[i][0]);
    end

    // R4 upper nibble ignored, lower loaded
    reg_write(8'hFA, 1);
    reg_read(1'b0, ok, d, dn);
    check("R4 load lower nibble", d, 8'h0A);
    check("R7 read done", dn, 1'b1);
    check("R7 read granted", ok, 1'b1);

    // R5 multi-byte and zero-count writes discarded
    reg_write(8'h0C, 2);
    reg_read(1'b0, ok, d, dn);
    check("R5 two-byte discard", d, 8'h0A);
    reg_write(8'h04, 32);
    reg_write(8'h02, 0);
    reg_read(1'b0, ok, d, dn);
    check("R5 long/zero discard", d, 8'h0A);

    // R8 back-to-back reads
    @(negedge clk); rd_en = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check($sformatf("R8 repeat read %0d", k), {rd_done, rd_ok, rd_data}, {2'b11, 8'h0A});
    end
    rd_en = 1'b0;

    // R9 busy refusal
    reg_read(1'b1, ok, d, dn);
    check("R9 busy done", dn, 1'b1);
    check("R9 busy refused", ok, 1'b0);
    check("R9 busy data", d, 8'h00);

    // R6 lock whole array
    reg_write(8'h0F, 1);
    reg_write(8'h00, 1);
    reg_read(1'b0, ok, d, dn);
    check("R6 locked setting kept", d, 8'h0F);
    probe(14'h0000, p);
    check("R6 still protected", p, 1'b1);
    check("R10 read while locked", ok, 1'b1);

    // R1 reset clears lock
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    reg_read(1'b0, ok, d, dn);
    check("R1 reset clears lock", d, 8'h00);
    reg_write(8'h08, 1);
    probe(14'h3000, p);
    check("R4 write after reset", p, 1'b1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule